// File: doc/BRIEF.md
# Single and Double Shock Detector

This block watches a stream of signed three-axis acceleration samples and recognises short impacts. A shock is a run of consecutive samples in which the magnitude of at least one enabled axis stays above a threshold. The run must end, by dropping back to or below the threshold, before a maximum duration is reached. One such pulse raises a single-shock event. A second pulse that starts inside a timed window, after a quiet latency period, raises a double-shock event instead.

All timing is counted in sample periods, and the counters only advance on clock cycles that carry a sample strobe. The two events are held in sticky flags and exposed in a status byte. A status-read pulse clears both flags. The surrounding logic supplies the threshold, the maximum duration, the latency and window lengths, and the per-axis enables. The block contains only the comparison and timing logic. It does not filter the samples or route the events to interrupt lines.

Top module: `shock_detector`

## Requirements
- R1: A sample is "above" when, on any axis whose enable bit is set, the absolute value of the signed reading is strictly greater than the unsigned threshold. Axes with a clear enable bit have no effect, and a magnitude equal to the threshold is not above.
- R2: A pulse of L consecutive above samples with 1 <= L < max duration that ends on a sample that is not above is qualified. A qualified first pulse sets status bit 6 (single) on the clock edge of that ending sample, so the bit is visible from that edge onward.
- R3: A pulse that reaches the max duration in above samples is discarded and sets no flag. The detector then ignores samples until one is not above, and then returns to idle. A max duration of 0 or 1 therefore never qualifies a pulse.
- R4: Number the ending sample of a qualified first pulse as index 0. If a second pulse starts at an index in the range latency+1 to latency+window, and that pulse also qualifies, status bit 5 (double) is set on its ending sample. Bit 6 is not set again by that second pulse.
- R5: An above sample at any index from 1 to latency cancels the double attempt. That pulse sets no flag, and the detector returns to idle once the signal falls.
- R6: If no pulse has started by index latency+window, the attempt lapses. A later pulse is then treated as a fresh first pulse and sets bit 6.
- R7: When the latency or the window is 0, double detection is off, and every qualified pulse sets bit 6.
- R8: Both flags are sticky. A status-read pulse clears both flags on the next edge, unless a new event for that flag arrives on the same edge, in which case the event wins. Status bits 7 and 4 to 0 always read 0.
- R9: Cycles without a sample strobe neither advance the timing nor change the detector state, whatever the acceleration inputs carry.
- R10: After a synchronous active-low reset, the status byte reads 0 and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; one sample per high cycle |
| acc_x | input | DW | Signed X acceleration |
| acc_y | input | DW | Signed Y acceleration |
| acc_z | input | DW | Signed Z acceleration |
| axis_en | input | 3 | Axis enables; bit 0 is X, bit 1 is Y, bit 2 is Z |
| thresh | input | DW | Unsigned magnitude threshold |
| max_dur | input | TW | Maximum pulse length in samples (exclusive) |
| latency | input | TW | Quiet period after the first pulse, in samples |
| window | input | TW | Period in which the second pulse may start, in samples |
| status_rd | input | 1 | Status read pulse; clears the flags |
| evt_status | output | 8 | Bit 6 is the single flag, bit 5 is the double flag, and all other bits are 0 |

## Verification
Both status bits are registered. Each bit changes on the same clock edge that samples the strobe ending a pulse, and a read clears the bits on the edge where the read is seen. No further cycles of delay apply. The bench's behavioural model, which tracks sample indices and run lengths, updates its expected flags on that same rising edge. The bench compares the whole status byte on every falling edge. Directed checks, taken at the falling edge right after the deciding strobe, pin down the boundary indices latency, latency+1 and latency+window, run lengths at and just below the max duration, and reads that collide with events.

// File: rtl/shock_pkg.sv
// Package: shared types for the shock detector.
// Assumes: nothing; only type definitions live here.
package shock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for a first pulse
        ST_PULSE1 = 3'd1,  // measuring the first pulse
        ST_LATENT = 3'd2,  // quiet period after the first pulse
        ST_WINDOW = 3'd3,  // second pulse may start here
        ST_PULSE2 = 3'd4,  // measuring the second pulse
        ST_HOLD   = 3'd5   // rejected pulse, wait for it to fall
    } shock_state_e;

    localparam int unsigned NUM_AXES = 3;
    localparam int unsigned BIT_SINGLE = 6;
    localparam int unsigned BIT_DOUBLE = 5;
endpackage

// File: rtl/shock_axis_cmp.sv
// Module: per-axis magnitude comparator.
// Does: reports whether any enabled axis has |value| > threshold.
// Assumes: two's complement inputs; the most negative value maps to its
//          true magnitude because the magnitude is taken as unsigned.
module shock_axis_cmp #(
    parameter int unsigned DW = 16,
    parameter int unsigned NA = 3
) (
    input  logic [NA*DW-1:0] acc_flat,
    input  logic [NA-1:0]    axis_en,
    input  logic [DW-1:0]    thresh,
    output logic             above
);
    logic [NA-1:0] over;

    for (genvar g = 0; g < NA; g++) begin : g_axis
        logic [DW-1:0] raw;
        logic [DW-1:0] mag;
        // Purpose: unsigned magnitude of one axis and its threshold test.
        always_comb begin
            raw     = acc_flat[g*DW +: DW];
            mag     = raw[DW-1] ? (~raw + 1'b1) : raw;
            over[g] = axis_en[g] && (mag > thresh);
        end
    end

    // Purpose: any enabled axis above threshold counts.
    always_comb above = |over;
endmodule

// File: rtl/shock_seq.sv
// Module: shock timing state machine.
// Does: measures pulse lengths, runs the latency and window timers, and
//       emits one-cycle event pulses for single and double shocks.
// Assumes: all timing only advances on smp_valid; configuration is
//          held steady while an attempt is in progress.
module shock_seq
    import shock_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          above,
    input  logic [TW-1:0] max_dur,
    input  logic [TW-1:0] latency,
    input  logic [TW-1:0] window,
    output logic          single_evt,
    output logic          double_evt
);
    localparam int unsigned CW = TW + 1;

    shock_state_e  state, state_n;
    logic [TW-1:0] cnt, cnt_n;
    logic [CW-1:0] inc;
    logic          room;      // one more above sample still qualifies
    logic          start_ok;  // a one-sample pulse may still qualify
    logic          dbl_on;

    // Purpose: shared comparisons for the next-state logic.
    always_comb begin
        inc      = {1'b0, cnt} + 1'b1;
        room     = inc < {1'b0, max_dur};
        start_ok = max_dur > TW'(1);
        dbl_on   = (latency != '0) && (window != '0);
    end

    // Purpose: next state, counter and event pulses per sample.
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        single_evt = 1'b0;
        double_evt = 1'b0;
        if (smp_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (above) begin
                        state_n = start_ok ? ST_PULSE1 : ST_HOLD;
                        cnt_n   = TW'(1);
                    end
                end
                ST_PULSE1: begin
                    if (above) begin
                        if (room) cnt_n = inc[TW-1:0];
                        else      state_n = ST_HOLD;
                    end else begin
                        single_evt = 1'b1;
                        state_n    = dbl_on ? ST_LATENT : ST_IDLE;
                        cnt_n      = '0;
                    end
                end
                ST_LATENT: begin
                    if (above) begin
                        state_n = ST_HOLD;
                    end else if (inc == {1'b0, latency}) begin
                        state_n = ST_WINDOW;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = inc[TW-1:0];
                    end
                end
                ST_WINDOW: begin
                    if (above) begin
                        state_n = start_ok ? ST_PULSE2 : ST_HOLD;
                        cnt_n   = TW'(1);
                    end else if (inc == {1'b0, window}) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = inc[TW-1:0];
                    end
                end
                ST_PULSE2: begin
                    if (above) begin
                        if (room) cnt_n = inc[TW-1:0];
                        else      state_n = ST_HOLD;
                    end else begin
                        double_evt = 1'b1;
                        state_n    = ST_IDLE;
                        cnt_n      = '0;
                    end
                end
                ST_HOLD: begin
                    if (!above) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // Purpose: state and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(state) && $stable(cnt)));
    assert_event_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (single_evt || double_evt) |-> smp_valid);
    assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_evt && double_evt));
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE));
endmodule

// File: rtl/shock_flags.sv
// Module: sticky event flags.
// Does: latches single and double events until a status read.
// Assumes: set pulses are one cycle wide; a set beats a same-cycle read.
module shock_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_single,
    input  logic set_double,
    input  logic rd,
    output logic single_q,
    output logic double_q
);
    // Purpose: flag registers with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q <= 1'b0;
            double_q <= 1'b0;
        end else begin
            single_q <= set_single | (single_q & ~rd);
            double_q <= set_double | (double_q & ~rd);
        end
    end

    assert_read_clears_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_single) |=> !single_q);
    assert_read_clears_double_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_double) |=> !double_q);
    assert_single_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (single_q && !rd) |=> single_q);
    assert_double_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (double_q && !rd) |=> double_q);
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!single_q && !double_q));
endmodule

// File: rtl/shock_detector.sv
// Module: single and double shock detector (top).
// Does: compares the three axes against a threshold, times pulses and
//       gaps in sample periods, and holds the events in a status byte.
// Assumes: one sample per smp_valid cycle; configuration is static
//          during a detection attempt.
module shock_detector
    import shock_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned TW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] acc_x,
    input  logic signed [DW-1:0] acc_y,
    input  logic signed [DW-1:0] acc_z,
    input  logic [2:0]           axis_en,
    input  logic [DW-1:0]        thresh,
    input  logic [TW-1:0]        max_dur,
    input  logic [TW-1:0]        latency,
    input  logic [TW-1:0]        window,
    input  logic                 status_rd,
    output logic [7:0]           evt_status
);
    logic [NUM_AXES*DW-1:0] acc_flat;
    logic above, single_evt, double_evt, single_q, double_q;

    // Purpose: pack the axes, Z in the top slice and X in the bottom.
    always_comb acc_flat = {acc_z, acc_y, acc_x};

    shock_axis_cmp #(.DW(DW), .NA(NUM_AXES)) i_cmp (
        .acc_flat (acc_flat),
        .axis_en  (axis_en),
        .thresh   (thresh),
        .above    (above)
    );

    shock_seq #(.TW(TW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .above      (above),
        .max_dur    (max_dur),
        .latency    (latency),
        .window     (window),
        .single_evt (single_evt),
        .double_evt (double_evt)
    );

    shock_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_single (single_evt),
        .set_double (double_evt),
        .rd         (status_rd),
        .single_q   (single_q),
        .double_q   (double_q)
    );

    // Purpose: place the flags at their status bit positions.
    always_comb begin
        evt_status             = '0;
        evt_status[BIT_SINGLE] = single_q;
        evt_status[BIT_DOUBLE] = double_q;
    end

    assert_spare_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status[7] == 1'b0) && (evt_status[4:0] == 5'b0));
endmodule

// File: tb/test_shock_detector.sv
module test_shock_detector;
    localparam int DW = 16;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] acc_x = '0, acc_y = '0, acc_z = '0;
    logic [2:0] axis_en = 3'b111;
    logic [DW-1:0] thresh = 16'd100;
    logic [TW-1:0] max_dur = 8'd4, latency = 8'd2, window = 8'd3;
    logic status_rd = 1'b0;
    logic [7:0] evt_status;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    always #2 clk = ~clk;

    shock_detector #(.DW(DW), .TW(TW)) i_shock_detector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
        .axis_en(axis_en), .thresh(thresh), .max_dur(max_dur),
        .latency(latency), .window(window), .status_rd(status_rd),
        .evt_status(evt_status)
    );

    // Reference model: sample indices and run lengths.
    int  m_idx, m_run, m_kind, m_end;  // kind: 0 none, 1 first, 2 second, 3 ignored
    bit  m_armed, m_s, m_d;

    function automatic bit is_above(int x, int y, int z);
        int ax = (x < 0) ? -x : x;
        int ay = (y < 0) ? -y : y;
        int az = (z < 0) ? -z : z;
        int t  = int'(thresh);
        return (axis_en[0] && ax > t) || (axis_en[1] && ay > t) || (axis_en[2] && az > t);
    endfunction

    always @(posedge clk) begin
        bit s_set, d_set, hit;
        int d;
        s_set = 1'b0; d_set = 1'b0;
        if (!rst_n) begin
            m_idx = 0; m_run = 0; m_kind = 0; m_end = 0;
            m_armed = 1'b0; m_s = 1'b0; m_d = 1'b0;
        end else begin
            if (smp_valid) begin
                hit = is_above(int'(acc_x), int'(acc_y), int'(acc_z));
                m_idx++;
                if (hit) begin
                    if (m_kind == 0) begin
                        m_kind = 1;
                        if (m_armed) begin
                            d = m_idx - m_end;
                            if (d <= int'(latency)) m_kind = 3;
                            else if (d <= int'(latency) + int'(window)) m_kind = 2;
                            m_armed = 1'b0;
                        end
                        m_run = 1;
                    end else begin
                        m_run++;
                    end
                    if ((m_kind == 1 || m_kind == 2) && m_run >= int'(max_dur)) m_kind = 3;
                end else begin
                    if (m_kind == 1) begin
                        s_set = 1'b1;
                        if (latency != 0 && window != 0) begin
                            m_armed = 1'b1; m_end = m_idx;
                        end
                    end else if (m_kind == 2) begin
                        d_set = 1'b1;
                    end
                    m_kind = 0; m_run = 0;
                end
            end
            if (s_set) m_s = 1'b1; else if (status_rd) m_s = 1'b0;
            if (d_set) m_d = 1'b1; else if (status_rd) m_d = 1'b0;
        end
    end

    // Compare the whole status byte on every falling edge.
    always @(negedge clk) begin
        logic [7:0] exp_st;
        if (!done) begin
            exp_st = 8'h00;
            exp_st[6] = m_s;
            exp_st[5] = m_d;
            n_checks++;
            if (evt_status !== exp_st) begin
                n_fail++;
                $display("FAIL %s model compare: actual %02h expected %02h at %0t",
                         cur_req, evt_status, exp_st, $time);
            end
        end
    end

    task automatic check(string req, logic [7:0] exp_st);
        n_checks++;
        if (evt_status !== exp_st) begin
            n_fail++;
            $display("FAIL %s directed: actual %02h expected %02h", req, evt_status, exp_st);
        end
    endtask

    task automatic smp(int x, int y = 0, int z = 0);
        @(negedge clk);
        smp_valid = 1'b1;
        acc_x = DW'(x); acc_y = DW'(y); acc_z = DW'(z);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) smp(0);
    endtask

    task automatic pulse(int n, int mag = 500);
        for (int i = 0; i < n; i++) smp(mag);
    endtask

    task automatic read_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";
        check("R10", 8'h00);
        rst_n = 1'b1;

        // R2: single pulse of length 2, max 4; double disabled here
        cur_req = "R2"; latency = 8'd0;
        quiet(1); pulse(2); check("R2", 8'h00); smp(0);
        check("R2", 8'h40);
        read_status(); check("R8", 8'h00);

        // R3: length equal to max_dur rejected; length max-1 accepted
        cur_req = "R3";
        pulse(4); pulse(3); smp(0); check("R3", 8'h00);
        pulse(3); smp(0); check("R3", 8'h40);
        read_status();
        max_dur = 8'd1; pulse(1); smp(0); check("R3", 8'h00);
        max_dur = 8'd4;

        // R1: disabled axis, equality, negative magnitude, most-negative value
        cur_req = "R1"; axis_en = 3'b101;
        smp(0, 30000, 0); smp(0); check("R1", 8'h00);
        smp(0, 0, 100); smp(0); check("R1", 8'h00);
        smp(0, 0, -101); smp(0); check("R1", 8'h40);
        read_status();
        smp(-32768, 0, 0); smp(0); check("R1", 8'h40);
        read_status(); axis_en = 3'b111;

        // R4: double with second start at lat+1 and at lat+win
        cur_req = "R4"; latency = 8'd2; window = 8'd3;
        pulse(2); smp(0); quiet(2); pulse(1); smp(0); check("R4", 8'h60);
        read_status();
        pulse(1); smp(0); quiet(4); pulse(2); smp(0); check("R4", 8'h60);
        read_status();

        // R5: crossing at index latency cancels
        cur_req = "R5";
        pulse(1); smp(0); quiet(1); pulse(1); smp(0); check("R5", 8'h40);
        read_status();
        quiet(6);

        // R6: start at lat+win+1 is a fresh single
        cur_req = "R6";
        pulse(1); smp(0); check("R6", 8'h40); read_status();
        quiet(5); pulse(1); smp(0); check("R6", 8'h40);
        read_status(); quiet(6);

        // R7: window zero disables double
        cur_req = "R7"; window = 8'd0;
        pulse(1); smp(0); quiet(2); pulse(1); smp(0); check("R7", 8'h40);
        read_status(); window = 8'd3;

        // R9: idle cycles between strobes do not advance timing
        cur_req = "R9";
        pulse(1); smp(0);
        @(negedge clk); acc_x = 16'sd900; repeat (20) @(negedge clk); acc_x = '0;
        smp(0); smp(0); pulse(1); smp(0); check("R9", 8'h60);
        read_status();

        // R8: read colliding with a new single event, event wins
        cur_req = "R8"; latency = 8'd0;
        pulse(1);
        @(negedge clk); smp_valid = 1'b1; acc_x = '0; status_rd = 1'b1;
        @(negedge clk); smp_valid = 1'b0; status_rd = 1'b0;
        check("R8", 8'h40);
        read_status(); check("R8", 8'h00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule